// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 32 pads. Software uses a simple register bus to choose, per pin, whether the pin drives or receives. It changes output levels through a write-ones-to-set register and a write-ones-to-clear register, so no read-modify-write is needed. It reads the pad levels through a two-flop synchronizer.

Each pin can be armed for rising edges, falling edges, both, or neither. Each of the two arming masks has its own set register and its own clear register. An armed edge latches a bit in a 32-bit status word, and software clears that bit by writing a one. The pins are split into two banks of 16. Each bank drives its own level-sensitive interrupt line, and each line is gated by a bank enable bit.

The bus is one cycle per access. A write is taken on the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i`. Register offsets:

| Offset | Register |
|---|---|
| 0x08 | bank enable |
| 0x10 | direction |
| 0x14 | output data |
| 0x18 | output set |
| 0x1C | output clear |
| 0x20 | input data |
| 0x24 | rise arm set |
| 0x28 | rise arm clear |
| 0x2C | fall arm set |
| 0x30 | fall arm clear |
| 0x34 | status |

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the following hold:
  - direction reads 0xFFFFFFFF, so every pin is an input.
  - output data, both arming masks, status and bank enable read 0.
  - `pad_oe_o` is 0 and `irq_o` is 0.
- R2: A direction bit of 1 makes the pin an input, with `pad_oe_o` low for that bit. A direction bit of 0 makes it an output, with `pad_oe_o` high.
- R3: Writing a mask to the output set register (0x18) drives high every pin whose mask bit is 1. Writing a mask to the output clear register (0x1C) drives those pins low. Mask bits of 0 leave their pins unchanged. Both registers, and 0x14, read back the output data shown on `pad_o`.
- R4: The input data register (0x20) shows the pad level two clock edges after the pad changes. A read one edge after the change still returns the old level. The register shows the pad level whether the pin is an input or an output.
- R5: The rise arm mask is set by ones written to 0x24 and cleared by ones written to 0x28. The fall arm mask uses 0x2C and 0x30 in the same way. Both registers of a pair read back their mask.
- R6: A 0-to-1 change of a pin's synchronized level sets that pin's status bit only when the pin's rise arm bit is 1.
- R7: A 1-to-0 change of a pin's synchronized level sets that pin's status bit only when the pin's fall arm bit is 1.
- R8: Writing a 1 to a status bit (0x34) clears it. Writing 0 leaves it unchanged.
- R9: If a new armed edge and a clearing write to the same status bit happen in the same cycle, the bit stays set.
- R10: Bank enable (0x08) holds one bit per bank, with bit 0 for bank 0 and bit 1 for bank 1. Writing 0x1F enables both banks and reads back 0x3. `irq_o[b]` can be high only when enable bit b is 1.
- R11: `irq_o[0]` is high while any of status bits 15:0 is set and bank 0 is enabled. `irq_o[1]` behaves the same way for status bits 31:16 and bank 1. Each line stays high until every status bit of its bank is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| pad_i | input | 32 | Pad levels |
| pad_o | output | 32 | Output data to pads |
| pad_oe_o | output | 32 | Output enable per pad |
| irq_o | output | 2 | Interrupt line per bank |

## Verification
The bench reads the input register one edge after a pad change, then again one edge later.
- A design with a missing synchronizer stage would show the new level too early.
- A design with an extra stage would show it too late.

The bench times a status clear so it lands in the same cycle as a fresh armed edge. A design that lets the clear win would drop that edge.

The bench drives edges on unarmed pins and edges in the unarmed direction. A design that mixed up the rise and fall masks, or ignored arming altogether, would show stray status bits.

Finally, the bench clears one bank's bits while the other bank's bits stay set, and turns one bank's enable off. A design that swapped the bank halves, or left out the enable gating, would show the wrong interrupt line.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFF_BANK_EN = 8'h08;
  localparam logic [7:0] OFF_DIR     = 8'h10;
  localparam logic [7:0] OFF_OUT     = 8'h14;
  localparam logic [7:0] OFF_OUT_SET = 8'h18;
  localparam logic [7:0] OFF_OUT_CLR = 8'h1C;
  localparam logic [7:0] OFF_IN      = 8'h20;
  localparam logic [7:0] OFF_RISE_S  = 8'h24;
  localparam logic [7:0] OFF_RISE_C  = 8'h28;
  localparam logic [7:0] OFF_FALL_S  = 8'h2C;
  localparam logic [7:0] OFF_FALL_C  = 8'h30;
  localparam logic [7:0] OFF_STATUS  = 8'h34;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      dly_q  <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = dly_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] arm_rise_i,
  input  logic [W-1:0] arm_fall_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] event_w, status_q;

  always_comb begin
    event_w = (cur_i & ~prev_i & arm_rise_i) | (~cur_i & prev_i & arm_fall_i);
  end

  // new edge beats a clear landing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | event_w;
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W      = 32,
  parameter int BANK_W = 16,
  localparam int NB    = W / BANK_W
) (
  input  logic [W-1:0]  status_i,
  input  logic [NB-1:0] bank_en_i,
  output logic [NB-1:0] irq_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign irq_o[b] = bank_en_i[b] & (|status_i[b*BANK_W +: BANK_W]);
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int NB     = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      in_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      arm_rise_o,
  output logic [W-1:0]      arm_fall_o,
  output logic [NB-1:0]     bank_en_o,
  output logic [W-1:0]      status_clr_o
);
  logic [W-1:0]  dir_q, out_q, rise_q, fall_q;
  logic [NB-1:0] ben_q;
  logic          wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      ben_q  <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFF_BANK_EN: ben_q  <= wdata_i[NB-1:0];
        OFF_DIR:     dir_q  <= wdata_i;
        OFF_OUT:     out_q  <= wdata_i;
        OFF_OUT_SET: out_q  <= out_q | wdata_i;
        OFF_OUT_CLR: out_q  <= out_q & ~wdata_i;
        OFF_RISE_S:  rise_q <= rise_q | wdata_i;
        OFF_RISE_C:  rise_q <= rise_q & ~wdata_i;
        OFF_FALL_S:  fall_q <= fall_q | wdata_i;
        OFF_FALL_C:  fall_q <= fall_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign status_clr_o = (wr && addr_i == OFF_STATUS) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_BANK_EN:                          rdata_o[NB-1:0] = ben_q;
      OFF_DIR:                              rdata_o = dir_q;
      OFF_OUT, OFF_OUT_SET, OFF_OUT_CLR:    rdata_o = out_q;
      OFF_IN:                               rdata_o = in_i;
      OFF_RISE_S, OFF_RISE_C:               rdata_o = rise_q;
      OFF_FALL_S, OFF_FALL_C:               rdata_o = fall_q;
      OFF_STATUS:                           rdata_o = status_i;
      default:                              rdata_o = '0;
    endcase
  end

  assign dir_o      = dir_q;
  assign out_o      = out_q;
  assign arm_rise_o = rise_q;
  assign arm_fall_o = fall_q;
  assign bank_en_o  = ben_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int N_PINS = 32,
  parameter int BANK_W = 16,
  parameter int ADDR_W = 8,
  localparam int NB    = N_PINS / BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [NB-1:0]     irq_o
);
  logic [N_PINS-1:0] in_cur, in_prev, status, dir, arm_rise, arm_fall, st_clr;
  logic [NB-1:0]     bank_en;

  gpio_in_sync #(.W(N_PINS)) u_sync (
    .clk_i, .rst_ni, .pad_i, .cur_o(in_cur), .prev_o(in_prev)
  );

  gpio_reg_file #(.W(N_PINS), .NB(NB), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .in_i(in_cur), .status_i(status), .dir_o(dir), .out_o(pad_o),
    .arm_rise_o(arm_rise), .arm_fall_o(arm_fall), .bank_en_o(bank_en),
    .status_clr_o(st_clr)
  );

  gpio_edge_status #(.W(N_PINS)) u_edge (
    .clk_i, .rst_ni, .cur_i(in_cur), .prev_i(in_prev),
    .arm_rise_i(arm_rise), .arm_fall_i(arm_fall), .clr_i(st_clr),
    .status_o(status)
  );

  gpio_bank_irq #(.W(N_PINS), .BANK_W(BANK_W)) u_irq (
    .status_i(status), .bank_en_i(bank_en), .irq_o
  );

  assign pad_oe_o = ~dir;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int BANK_W = 16,
  parameter int NB     = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      pad_o,
  input logic [W-1:0]      pad_oe_o,
  input logic [NB-1:0]     irq_o,
  input logic [W-1:0]      status,
  input logic [W-1:0]      arm_rise,
  input logic [W-1:0]      arm_fall,
  input logic [NB-1:0]     bank_en
);
  assert_dir_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_DIR) |=> pad_oe_o == ~$past(wdata_i));

  assert_out_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_OUT_SET) |=> (pad_o & $past(wdata_i)) == $past(wdata_i));

  assert_out_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_OUT_CLR) |=> (pad_o & $past(wdata_i)) == '0);

  assert_only_armed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & ~$past(status)) & ~($past(arm_rise) | $past(arm_fall))) == '0);

  for (genvar b = 0; b < NB; b++) begin : g_b
    assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[b] |-> bank_en[b]);
    assert_irq_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_en[b] && status[b*BANK_W +: BANK_W] != '0) |-> irq_o[b]);
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .W(N_PINS), .BANK_W(BANK_W), .NB(NB), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o),
  .status(status), .arm_rise(arm_rise), .arm_fall(arm_fall), .bank_en(bank_en)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic [1:0]  irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct {
    int          sel;  // 0 rdata, 1 irq, 2 pad_o, 3 pad_oe
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // monitor: compare pending expectation away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = {30'd0, irq};
        2: act = pad_out;
        default: act = pad_oe;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 0; we = 0;
  endtask

  task automatic chk(int sel, logic [7:0] a, logic [31:0] e, string tag);
    @(posedge clk); #2;
    addr = a;
    sbq.push_back('{sel: sel, exp: e, tag: tag});
  endtask

  task automatic set_pad(logic [31:0] p);
    @(posedge clk); #2;
    pad_in = p;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R1 reset state
    chk(0, 8'h10, 32'hFFFF_FFFF, "R1 dir");
    chk(0, 8'h14, 32'h0, "R1 out");
    chk(0, 8'h24, 32'h0, "R1 rise arm");
    chk(0, 8'h2C, 32'h0, "R1 fall arm");
    chk(0, 8'h34, 32'h0, "R1 status");
    chk(0, 8'h08, 32'h0, "R1 bank en");
    chk(1, 8'h0, 32'h0, "R1 irq");
    chk(3, 8'h0, 32'h0, "R1 oe");
    // R2 direction
    wr(8'h10, 32'hFFFF_00F0);
    chk(3, 8'h0, 32'h0000_FF0F, "R2 oe");
    chk(0, 8'h10, 32'hFFFF_00F0, "R2 dir readback");
    // R3 atomic set/clear
    wr(8'h18, 32'h0000_00A5);
    chk(2, 8'h0, 32'h0000_00A5, "R3 set");
    wr(8'h18, 32'h0000_0F00);
    chk(2, 8'h0, 32'h0000_0FA5, "R3 set keeps");
    wr(8'h1C, 32'h0000_0005);
    chk(2, 8'h0, 32'h0000_0FA0, "R3 clear");
    chk(0, 8'h14, 32'h0000_0FA0, "R3 out read");
    chk(0, 8'h1C, 32'h0000_0FA0, "R3 clr readback");
    // R4 synchronized input, pin 0 is an output
    set_pad(32'h8000_0001);
    chk(0, 8'h20, 32'h0, "R4 stale");
    chk(0, 8'h20, 32'h8000_0001, "R4 synced");
    tick(3);
    chk(0, 8'h34, 32'h0, "R6 unarmed no status");
    // R5 arming
    wr(8'h24, 32'h0000_0009);
    wr(8'h2C, 32'h0001_0008);
    chk(0, 8'h24, 32'h0000_0009, "R5 rise set rd");
    chk(0, 8'h28, 32'h0000_0009, "R5 rise clr rd");
    chk(0, 8'h2C, 32'h0001_0008, "R5 fall rd");
    wr(8'h28, 32'h0000_0008);
    chk(0, 8'h24, 32'h0000_0001, "R5 rise after clr");
    // R6 rising: bit3 rises unarmed, bit31 falls unarmed
    set_pad(32'h0000_0009);
    tick(4);
    chk(0, 8'h34, 32'h0, "R6 unarmed edges");
    set_pad(32'h0000_0008); // bit0 falls, fall not armed
    tick(4);
    chk(0, 8'h34, 32'h0, "R7 unarmed fall");
    set_pad(32'h0000_0009); // bit0 rises, armed
    tick(4);
    chk(0, 8'h34, 32'h0000_0001, "R6 armed rise");
    // R7 falling: bit3 then bit16
    set_pad(32'h0000_0001);
    tick(4);
    chk(0, 8'h34, 32'h0000_0009, "R7 fall bit3");
    set_pad(32'h0001_0001);
    tick(4);
    chk(0, 8'h34, 32'h0000_0009, "R6 bit16 rise unarmed");
    set_pad(32'h0000_0001);
    tick(4);
    chk(0, 8'h34, 32'h0001_0009, "R7 fall bit16");
    // R10 bank enables
    chk(1, 8'h0, 32'h0, "R10 disabled");
    wr(8'h08, 32'h0000_001F);
    chk(0, 8'h08, 32'h3, "R10 en readback");
    chk(1, 8'h0, 32'h3, "R10 both irq");
    // R8/R11 clear
    wr(8'h34, 32'h0);
    chk(0, 8'h34, 32'h0001_0009, "R8 zero write");
    wr(8'h34, 32'h0000_0009);
    chk(0, 8'h34, 32'h0001_0000, "R8 w1c");
    chk(1, 8'h0, 32'h2, "R11 bank1 holds");
    wr(8'h08, 32'h0000_0001);
    chk(1, 8'h0, 32'h0, "R10 bank1 gated");
    // R9 edge vs clear
    set_pad(32'h0);
    tick(4);
    set_pad(32'h1);
    tick(4);
    chk(0, 8'h34, 32'h0001_0001, "R6 rise again");
    chk(1, 8'h0, 32'h1, "R11 bank0 irq");
    set_pad(32'h0);
    tick(4);
    set_pad(32'h1);
    @(posedge clk);
    wr(8'h34, 32'h0000_0001);
    chk(0, 8'h34, 32'h0001_0001, "R9 edge wins");
    wr(8'h34, 32'h0000_0001);
    chk(0, 8'h34, 32'h0001_0000, "R9 later clear");
    chk(1, 8'h0, 32'h0, "R11 bank0 low");
    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule